// File: doc/BRIEF.md
# Streaming Connected-Component Bounding-Box Extractor

This block watches a binary image arrive one pixel per clock in raster order and reports the bounding box of every 8-connected foreground region. It makes one scan over the frame and stores no frame. It keeps two rows of per-column labels: the row being scanned and the row above it. It also keeps a table of label slots, each holding a slot state and a growing box. Each foreground pixel either continues a label from its left or upper neighbours or opens a new one. When two labels meet, they merge into one.

A region is complete at the end of the first row that does not extend it. Its box is then queued and driven out with a one-cycle valid pulse, while the stream keeps flowing. Every region still open at the last row of the frame is flushed the same way. Label slots are released on merge and on emission, so the number of regions per frame is not bounded by the table size. Image width and height are parameters, and all storage is sized from them.

Top module: `cc_bbox_stream`

## Requirements
- R1: While `rst` is high and in the cycle after, `out_valid` is 0. The first valid pixel after reset is taken as row 0, column 0, even if reset arrived mid-frame.
- R2: `out_box` packs four fields. From the most significant bit down they are the smallest column, largest column, smallest row and largest row. Column fields are clog2(IMG_W) bits and row fields are clog2(IMG_H) bits. Each box is reported in a single cycle with `out_valid` high.
- R3: Foreground pixels that touch only at a corner belong to the same region. This includes a pixel whose only link is the upper-right pixel of the row above.
- R4: When separate partial regions join further down, such as the two arms of a U or a V, or several runs bridged by one run below, exactly one box is reported. That box is the union of all parts.
- R5: Each region is reported exactly once. More regions than there are label slots can be reported, across a frame and across consecutive frames.
- R6: Let E be the clock edge that takes the last pixel of the first row after a region's lowest row. For a region that ends on the last row, E is the edge that takes the frame's last pixel. The region's box appears after edge E and no later than IMG_W+1 edges after E.
- R7: A pixel is consumed only on a cycle with `in_valid` high. Idle cycles inside a row change no result.
- R8: One pixel is accepted on every clock with no stall input. A full-rate frame, including an empty frame and an all-foreground frame, gives the correct boxes.
- R9: Frames are independent. Foreground on the last row of one frame never joins foreground on the first row of the next frame, even when the frames are back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `pix_in` on this cycle |
| pix_in | input | 1 | Binary pixel, 1 = foreground, raster order |
| out_valid | output | 1 | One-cycle pulse per reported box |
| out_box | output | 2*clog2(IMG_W)+2*clog2(IMG_H) | {col min, col max, row min, row max} |

## Verification
A box becomes due only after the row-closing edge E defined in R6. At that edge its slot turns done. The output register loads it one edge later at the earliest, and at most one box leaves per clock, so the latest arrival is IMG_W+1 edges after E. The bench numbers every clock edge, records the edge at which each row's last pixel is taken, and records the edge after which each box is seen (sampling on the falling clock). It then checks that each expected box lies strictly after its E and within that bound. Box contents and counts are matched as multisets against regions found by an independent relaxation labelling in the bench, so the order in which boxes leave the block does not matter.

// File: rtl/ccbox_pkg.sv
package ccbox_pkg;

    // Lifecycle of one label slot
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_OPEN = 2'd1,
        SLOT_DONE = 2'd2
    } slot_e;

    // Bits needed to index n distinct values (at least 1)
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Slots needed for a row width: open labels of the upper row, of the
    // current row and closed ones still waiting to leave, plus unused slot 0
    function automatic int slot_count(input int width);
        return 2 * width + 1;
    endfunction

endpackage

// File: rtl/ccbox_raster.sv
module ccbox_raster #(
    parameter int IMG_W = 16,
    parameter int IMG_H = 8,
    localparam int CW = ccbox_pkg::idx_bits(IMG_W),
    localparam int RW = ccbox_pkg::idx_bits(IMG_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row,
    output logic          row_end,
    output logic          frame_end
);
    localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);

    assign row_end   = in_valid && (col == COL_LAST);
    assign frame_end = row_end && (row == ROW_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            row <= '0;
        end else if (in_valid) begin
            if (col == COL_LAST) begin
                col <= '0;
                row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccbox_first_set.sv
module ccbox_first_set #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end
endmodule

// File: rtl/ccbox_link.sv
module ccbox_link #(
    parameter int LW = 6
) (
    input  logic [LW-1:0] left_lab,
    input  logic [LW-1:0] up_l,
    input  logic [LW-1:0] up_m,
    input  logic [LW-1:0] up_r,
    output logic [LW-1:0] keep_lab,
    output logic [LW-1:0] drop_lab,
    output logic          fresh,
    output logic          join_hit
);
    logic [LW-1:0] second;

    // Left and upper neighbours already share a label, so at most two
    // distinct labels can meet at one pixel.
    always_comb begin
        if (left_lab != '0)      keep_lab = left_lab;
        else if (up_m != '0)     keep_lab = up_m;
        else if (up_l != '0)     keep_lab = up_l;
        else                     keep_lab = up_r;

        if (left_lab != '0)                      second = up_r;
        else if (up_m == '0 && up_l != '0)       second = up_r;
        else                                     second = '0;
    end

    assign fresh    = (keep_lab == '0);
    assign join_hit = (second != '0) && (second != keep_lab);
    assign drop_lab = second;
endmodule

// File: rtl/cc_bbox_stream.sv
module cc_bbox_stream #(
    parameter int IMG_W = 16,
    parameter int IMG_H = 8,
    localparam int CW    = ccbox_pkg::idx_bits(IMG_W),
    localparam int RW    = ccbox_pkg::idx_bits(IMG_H),
    localparam int BOX_W = 2 * CW + 2 * RW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             pix_in,
    output logic             out_valid,
    output logic [BOX_W-1:0] out_box
);
    import ccbox_pkg::*;

    localparam int NL = slot_count(IMG_W);
    localparam int LW = idx_bits(NL);

    typedef logic [LW-1:0] lab_t;
    typedef struct packed {
        logic [CW-1:0] c_lo;
        logic [CW-1:0] c_hi;
        logic [RW-1:0] r_lo;
        logic [RW-1:0] r_hi;
    } box_t;

    function automatic box_t box_union(input box_t a, input box_t b);
        box_t u;
        u.c_lo = (a.c_lo < b.c_lo) ? a.c_lo : b.c_lo;
        u.c_hi = (a.c_hi > b.c_hi) ? a.c_hi : b.c_hi;
        u.r_lo = (a.r_lo < b.r_lo) ? a.r_lo : b.r_lo;
        u.r_hi = (a.r_hi > b.r_hi) ? a.r_hi : b.r_hi;
        return u;
    endfunction

    // Raster position
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic          row_end, frame_end;

    ccbox_raster #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_raster (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .col(col), .row(row), .row_end(row_end), .frame_end(frame_end)
    );

    // State
    lab_t  above_q [IMG_W];
    lab_t  above_d [IMG_W];
    lab_t  here_q  [IMG_W];
    lab_t  here_d  [IMG_W];
    slot_e st_q    [NL];
    slot_e st_d    [NL];
    box_t  box_q   [NL];
    box_t  box_d   [NL];
    logic  seen_q  [NL];
    logic  seen_d  [NL];

    // Slot selection
    logic [NL-1:0] free_vec, done_vec;
    logic          free_found, emit_found;
    lab_t          free_idx, emit_idx;

    for (genvar k = 0; k < NL; k++) begin : g_vec
        if (k == 0) begin : g_zero
            assign free_vec[k] = 1'b0;
            assign done_vec[k] = 1'b0;
        end else begin : g_slot
            assign free_vec[k] = (st_q[k] == SLOT_FREE);
            assign done_vec[k] = (st_q[k] == SLOT_DONE);
        end
    end

    ccbox_first_set #(.N(NL), .IW(LW)) u_alloc (
        .req(free_vec), .found(free_found), .idx(free_idx)
    );
    ccbox_first_set #(.N(NL), .IW(LW)) u_emit (
        .req(done_vec), .found(emit_found), .idx(emit_idx)
    );

    // Neighbourhood
    lab_t nb_left, nb_ul, nb_um, nb_ur, link_keep, link_drop;
    logic fresh, join_hit;
    logic [CW-1:0] col_m1, col_p1;

    assign col_m1 = col - 1'b1;
    assign col_p1 = col + 1'b1;

    always_comb begin
        nb_um   = above_q[col];
        nb_ul   = (col != '0) ? above_q[col_m1] : '0;
        nb_left = (col != '0) ? here_q[col_m1]  : '0;
        nb_ur   = (col != CW'(IMG_W - 1)) ? above_q[col_p1] : '0;
    end

    ccbox_link #(.LW(LW)) u_link (
        .left_lab(nb_left), .up_l(nb_ul), .up_m(nb_um), .up_r(nb_ur),
        .keep_lab(link_keep), .drop_lab(link_drop),
        .fresh(fresh), .join_hit(join_hit)
    );

    // Next state
    lab_t cur_lab;
    box_t px_box, grow_box;

    always_comb begin
        above_d = above_q;
        here_d  = here_q;
        st_d    = st_q;
        box_d   = box_q;
        seen_d  = seen_q;

        cur_lab     = fresh ? free_idx : link_keep;
        px_box.c_lo = col;
        px_box.c_hi = col;
        px_box.r_lo = row;
        px_box.r_hi = row;
        grow_box    = fresh ? px_box : box_union(box_q[cur_lab], px_box);
        if (join_hit) begin
            grow_box = box_union(grow_box, box_q[link_drop]);
        end

        if (emit_found) begin
            st_d[emit_idx] = SLOT_FREE;
        end

        if (in_valid) begin
            if (pix_in) begin
                if (join_hit) begin
                    st_d[link_drop]   = SLOT_FREE;
                    seen_d[link_drop] = 1'b0;
                    for (int i = 0; i < IMG_W; i++) begin
                        if (above_d[i] == link_drop) above_d[i] = cur_lab;
                        if (here_d[i]  == link_drop) here_d[i]  = cur_lab;
                    end
                end
                box_d[cur_lab]  = grow_box;
                st_d[cur_lab]   = SLOT_OPEN;
                seen_d[cur_lab] = 1'b1;
                here_d[col]     = cur_lab;
            end else begin
                here_d[col] = '0;
            end

            if (row_end) begin
                for (int k = 1; k < NL; k++) begin
                    if (st_d[k] == SLOT_OPEN && (!seen_d[k] || frame_end)) begin
                        st_d[k] = SLOT_DONE;
                    end
                    seen_d[k] = 1'b0;
                end
                for (int i = 0; i < IMG_W; i++) begin
                    above_d[i] = frame_end ? '0 : here_d[i];
                    here_d[i]  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < IMG_W; i++) begin
                above_q[i] <= '0;
                here_q[i]  <= '0;
            end
            for (int k = 0; k < NL; k++) begin
                st_q[k]   <= SLOT_FREE;
                box_q[k]  <= '0;
                seen_q[k] <= 1'b0;
            end
            out_valid <= 1'b0;
            out_box   <= '0;
        end else begin
            above_q   <= above_d;
            here_q    <= here_d;
            st_q      <= st_d;
            box_q     <= box_d;
            seen_q    <= seen_d;
            out_valid <= emit_found;
            out_box   <= box_q[emit_idx];
        end
    end
endmodule

// File: rtl/cc_bbox_stream_chk.sv
module cc_bbox_stream_chk #(
    parameter int IMG_W = 16,
    parameter int IMG_H = 8,
    localparam int CW    = ccbox_pkg::idx_bits(IMG_W),
    localparam int RW    = ccbox_pkg::idx_bits(IMG_H),
    localparam int BOX_W = 2 * CW + 2 * RW
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             pix_in,
    input logic             out_valid,
    input logic [BOX_W-1:0] out_box,
    input logic             fresh,
    input logic             free_found,
    input logic [CW-1:0]    col,
    input logic [RW-1:0]    row,
    input logic             row_end
);
    logic [CW-1:0] c_lo, c_hi;
    logic [RW-1:0] r_lo, r_hi;
    assign {c_lo, c_hi, r_lo, r_hi} = out_box;

    // R2: minimum fields never exceed maximum fields
    a_r2_box_order: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (c_lo <= c_hi) && (r_lo <= r_hi));

    // R2: fields stay inside the image
    a_r2_box_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (c_hi <= CW'(IMG_W - 1)) && (r_hi <= RW'(IMG_H - 1)));

    // R5: a new label always finds a free slot
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pix_in && fresh) |-> free_found);

    // R8: every valid pixel inside a row advances the column by one
    a_r8_col_step: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !row_end) |=> (col == $past(col) + 1'b1) && (row == $past(row)));

    // R9: after the last row the scan restarts at the top
    a_r9_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        (row_end && row == RW'(IMG_H - 1)) |=> (row == '0) && (col == '0));
endmodule

bind cc_bbox_stream cc_bbox_stream_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pix_in(pix_in),
    .out_valid(out_valid), .out_box(out_box), .fresh(fresh),
    .free_found(free_found), .col(col), .row(row), .row_end(row_end)
);

// File: tb/cc_bbox_stream_tb.sv
module cc_bbox_stream_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int H = 8;
    localparam int CW = 4;
    localparam int RW = 3;
    localparam int BOX_W = 2 * CW + 2 * RW;
    localparam int NIMG = 10;

    // Stimulus table: one image per entry, element r is row r, bit c is column c
    localparam logic [W-1:0] IMGS [NIMG][H] = '{
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0000, 16'h0000, 16'h0020, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0001, 16'h0002, 16'h0004, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0000, 16'h0104, 16'h0104, 16'h01FC, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0041, 16'h0022, 16'h0014, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h5555, 16'h0000, 16'h5555, 16'h0000, 16'h5555, 16'h0000, 16'h5555, 16'h0000},
        '{16'h0003, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hF00F},
        '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
        '{16'h1111, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0021, 16'h001F, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
    };
    localparam string TAGS [NIMG] = '{"R8", "R2", "R3", "R4", "R4", "R5", "R6", "R8", "R4", "R3"};

    logic clk = 1'b0;
    logic rst, in_valid, pix_in, out_valid;
    logic [BOX_W-1:0] out_box;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cc_bbox_stream #(.IMG_W(W), .IMG_H(H)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pix_in(pix_in),
        .out_valid(out_valid), .out_box(out_box)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    // Recorded outputs
    int rec_box [256];
    int rec_t   [256];
    bit rec_used[256];
    int nrec = 0;

    always @(negedge clk) begin
        if (!rst && out_valid && nrec < 256) begin
            rec_box[nrec] = int'(out_box);
            rec_t[nrec]   = cyc;
            nrec++;
        end
    end

    // Expected boxes
    int exp_box [256];
    int exp_rhi [256];
    int nexp = 0;
    int row_edge [H];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int pack_box(input int cl, input int ch, input int rl, input int rh);
        return (cl << (CW + 2 * RW)) | (ch << (2 * RW)) | (rl << RW) | rh;
    endfunction

    // Independent labelling: relax minimum label over 8 neighbours
    task automatic build_expected(input int id);
        int lbl [H][W];
        bit changed;
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                lbl[r][c] = IMGS[id][r][c] ? (r * W + c + 1) : 0;
        changed = 1'b1;
        while (changed) begin
            changed = 1'b0;
            for (int r = 0; r < H; r++)
                for (int c = 0; c < W; c++)
                    if (lbl[r][c] != 0)
                        for (int dr = -1; dr <= 1; dr++)
                            for (int dc = -1; dc <= 1; dc++)
                                if (r + dr >= 0 && r + dr < H && c + dc >= 0 && c + dc < W)
                                    if (lbl[r+dr][c+dc] != 0 && lbl[r+dr][c+dc] < lbl[r][c]) begin
                                        lbl[r][c] = lbl[r+dr][c+dc];
                                        changed = 1'b1;
                                    end
        end
        for (int L = 1; L <= H * W; L++) begin
            int cl = W, ch = -1, rl = H, rh = -1;
            for (int r = 0; r < H; r++)
                for (int c = 0; c < W; c++)
                    if (lbl[r][c] == L) begin
                        if (c < cl) cl = c;
                        if (c > ch) ch = c;
                        if (r < rl) rl = r;
                        if (r > rh) rh = r;
                    end
            if (ch >= 0) begin
                exp_box[nexp] = pack_box(cl, ch, rl, rh);
                exp_rhi[nexp] = rh;
                nexp++;
            end
        end
    endtask

    task automatic clear_all();
        nrec = 0;
        nexp = 0;
        for (int j = 0; j < 256; j++) rec_used[j] = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            pix_in   = 1'b0;
        end
    endtask

    task automatic send_rows(input int id, input bit gaps, input int nrows);
        for (int r = 0; r < nrows; r++)
            for (int c = 0; c < W; c++) begin
                if (gaps && (c % 3 == 1)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    pix_in   = 1'b1;
                end
                @(negedge clk);
                in_valid = 1'b1;
                pix_in   = IMGS[id][r][c];
                if (c == W - 1) row_edge[r] = cyc + 1;
            end
        @(negedge clk);
        in_valid = 1'b0;
        pix_in   = 1'b0;
    endtask

    task automatic compare_all(input string tag, input bit timed);
        int missing = 0;
        int late = 0;
        chk(nrec == nexp, "R5", {tag, " box count"}, nrec, nexp);
        for (int i = 0; i < nexp; i++) begin
            int hit = -1;
            for (int j = 0; j < nrec; j++)
                if (hit < 0 && !rec_used[j] && rec_box[j] == exp_box[i]) hit = j;
            if (hit < 0) begin
                missing++;
                $display("FAIL %s missing box: actual none expected %0h", tag, exp_box[i]);
            end else begin
                int e;
                rec_used[hit] = 1'b1;
                e = (exp_rhi[i] < H - 1) ? row_edge[exp_rhi[i] + 1] : row_edge[H - 1];
                if (timed && (rec_t[hit] <= e || rec_t[hit] > e + W + 1)) begin
                    late++;
                    $display("FAIL R6 box %0h edge: actual %0d expected in (%0d,%0d]",
                             exp_box[i], rec_t[hit], e, e + W + 1);
                end
            end
        end
        n_tests++;
        if (missing != 0) n_fail++;
        if (timed) chk(late == 0, "R6", {tag, " timing"}, late, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        pix_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // Table walk, full rate
        for (int t = 0; t < NIMG; t++) begin
            clear_all();
            build_expected(t);
            send_rows(t, 1'b0, H);
            idle(2 * W + 4);
            compare_all(TAGS[t], 1'b1);
        end

        // R7: idle cycles inside rows
        clear_all();
        build_expected(3);
        send_rows(3, 1'b1, H);
        idle(2 * W + 4);
        compare_all("R7", 1'b1);
        clear_all();
        build_expected(4);
        send_rows(4, 1'b1, H);
        idle(2 * W + 4);
        compare_all("R7", 1'b1);

        // R9: back-to-back frames with touching edge rows
        clear_all();
        build_expected(6);
        build_expected(6);
        send_rows(6, 1'b0, H);
        send_rows(6, 1'b0, H);
        idle(2 * W + 4);
        compare_all("R9", 1'b0);

        // R5: more regions than slots over two frames
        clear_all();
        build_expected(5);
        build_expected(5);
        send_rows(5, 1'b0, H);
        send_rows(5, 1'b0, H);
        idle(3 * W + 4);
        compare_all("R5", 1'b0);

        // R1: reset mid-frame restarts the scan at row 0, column 0
        send_rows(7, 1'b0, H / 2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid mid-frame reset", int'(out_valid), 0);
        rst = 1'b0;
        clear_all();
        build_expected(1);
        send_rows(1, 1'b0, H);
        idle(2 * W + 4);
        compare_all("R1", 1'b1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule